// File: doc/BRIEF.md
# Interrupt Vector Priority Controller

This block arbitrates the interrupt requests of a small 8-bit CPU. It sees a reset request, a software trap request and twelve numbered peripheral request lines. When the CPU pulses its acknowledge input, the block selects one winner. Reset always beats the trap, and the trap beats every peripheral. Among peripherals the lowest source number wins. The block registers the winner's source number and its 16-bit vector address. Peripheral lines obey a per-line mask bit and a global interrupt-level permit. Reset and the trap ignore both.

The vector table descends from the top of the address space. Reset sits at FFFEh and the trap at FFFCh. Peripheral source n sits at FFFAh − 2·n, so source 11 lands at FFE4h. Sources 0 and 6 are holes in the map and are never granted.

The block also drives a combinational wakeup for the two low-power modes. Each source carries its own qualifier, and the mask has no effect on wakeup. The external-event sources 2–5 wake from both modes. Source 7 wakes only while its peripheral is a bus slave. Source 1 wakes only from the deeper-clocked active-halt mode. Sources 8–11 never wake the device. The asynchronous active-low reset is released through a two-stage synchronizer.

Top module: `irq_vector_arb`

## Requirements
- R1: For the first cycle after reset release, gnt_valid is 0, gnt_src is 31, gnt_vec is FFFEh, and wake is 0 while lp_mode is run (00).
- R2: An acknowledge cycle with rst_req high yields gnt_src 31 and gnt_vec FFFEh. This holds whatever the other inputs are, including level_ok 0.
- R3: An acknowledge cycle with trap_req high and rst_req low yields gnt_src 30 and gnt_vec FFFCh. Masks and level_ok have no effect on it.
- R4: With neither reset nor trap requested, the acknowledge grants the lowest-numbered eligible peripheral n. It reports gnt_src n and gnt_vec FFFAh − 2·n.
- R5: A peripheral is eligible only if its request is 1, its irq_mask bit is 0 and level_ok is 1.
- R6: Sources 0 and 6 are never granted. An acknowledge with no eligible source leaves gnt_valid 0 in the following cycle.
- R7: gnt_valid is 1 in exactly the cycle after an acknowledge that found a winner. gnt_src and gnt_vec change only after such an acknowledge and otherwise hold their values.
- R8: In halt mode (lp_mode 01), wake is 1 if any of these holds: irq_req[5:2] is non-zero, irq_req[7] is 1 with spi_slave 1, or rst_req is 1. Masks play no part.
- R9: In active-halt mode (lp_mode 10), wake follows the halt rule and is also raised by irq_req[1].
- R10: wake is 0 in run mode (00) and in the reserved mode (11). Source 1 never wakes from halt. Sources 8–11, source 0, source 6 and the trap never raise wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset request, highest priority |
| trap_req | input | 1 | Software trap request |
| irq_req | input | 12 | Peripheral request lines, index = source number |
| irq_mask | input | 12 | Per-source mask, 1 = blocked |
| level_ok | input | 1 | CPU interrupt level permits maskable sources |
| spi_slave | input | 1 | Serial peripheral is in slave mode |
| lp_mode | input | 2 | 00 run, 01 halt, 10 active-halt, 11 reserved |
| ack | input | 1 | CPU acknowledge pulse |
| gnt_valid | output | 1 | Grant result valid (one cycle after ack) |
| gnt_src | output | 5 | Granted source: 0–11 peripheral, 30 trap, 31 reset |
| gnt_vec | output | 16 | Vector address of the granted source |
| wake | output | 1 | Low-power wakeup request |

## Verification
A wrong priority chain or eligibility term gives a wrong gnt_src/gnt_vec pair one cycle after the acknowledge. Exhaustive single-source and pairwise sweeps expose it on the first such acknowledge. A corrupted grant register is caught by the valid check one cycle later. The hold checks on a later no-winner acknowledge catch it too. Wake qualification is purely combinational, so a wrong per-source qualifier shows on wake in the same cycle as the request. The sweep covers every source in every mode.

// File: rtl/irq_pkg.sv
package irq_pkg;

  localparam int unsigned SRC_W = 5;
  localparam logic [SRC_W-1:0] ID_RESET = 5'd31;
  localparam logic [SRC_W-1:0] ID_TRAP  = 5'd30;

  typedef enum logic [1:0] {
    LP_RUN   = 2'b00,
    LP_HALT  = 2'b01,
    LP_AHALT = 2'b10,
    LP_RSVD  = 2'b11
  } lp_mode_e;

  // Descending vector table: each slot is two bytes below the previous one.
  function automatic logic [15:0] vec_of(input logic [15:0] base,
                                         input logic [SRC_W-1:0] idx);
    return base - {10'd0, idx, 1'b0};
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
#(
  parameter int unsigned N = 12
) (
  input  logic [N-1:0]     elig,
  output logic             found,
  output logic [SRC_W-1:0] idx
);

  // Scan from the top down so the lowest index is the last one written.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = SRC_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_wake_qual.sv
module irq_wake_qual
  import irq_pkg::*;
#(
  parameter int unsigned N             = 12,
  parameter logic [N-1:0] HALT_SET     = 12'h03C,
  parameter logic [N-1:0] AHALT_EXTRA  = 12'h002,
  parameter int unsigned SLAVE_SRC     = 7
) (
  input  logic [N-1:0] req,
  input  logic [1:0]   mode,
  input  logic         slave,
  input  logic         rst_req,
  output logic         wake
);

  logic [N-1:0] halt_en;
  logic [N-1:0] ahalt_en;
  logic [N-1:0] qual;
  logic         in_halt;
  logic         in_ahalt;

  assign in_halt  = (mode == LP_HALT);
  assign in_ahalt = (mode == LP_AHALT);

  for (genvar i = 0; i < N; i++) begin : g_src
    if (i == SLAVE_SRC) begin : g_slave
      assign halt_en[i] = HALT_SET[i] | slave;
    end else begin : g_plain
      assign halt_en[i] = HALT_SET[i];
    end
    assign ahalt_en[i] = halt_en[i] | AHALT_EXTRA[i];
    assign qual[i] = req[i] & ((in_halt & halt_en[i]) | (in_ahalt & ahalt_en[i]));
  end

  assign wake = (|qual) | (rst_req & (in_halt | in_ahalt));

endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
  import irq_pkg::*;
#(
  parameter int unsigned  NUM_SRC     = 12,
  parameter logic [15:0]  VEC_TOP     = 16'hFFFE,
  parameter logic [NUM_SRC-1:0] UNUSED_SET  = 12'h041,
  parameter logic [NUM_SRC-1:0] HALT_SET    = 12'h03C,
  parameter logic [NUM_SRC-1:0] AHALT_EXTRA = 12'h002,
  parameter int unsigned  SLAVE_SRC   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_req,
  input  logic               trap_req,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_mask,
  input  logic               level_ok,
  input  logic               spi_slave,
  input  logic [1:0]         lp_mode,
  input  logic               ack,
  output logic               gnt_valid,
  output logic [4:0]         gnt_src,
  output logic [15:0]        gnt_vec,
  output logic               wake
);

  localparam logic [15:0] TRAP_VEC = VEC_TOP - 16'd2;
  localparam logic [15:0] PERI_VEC = VEC_TOP - 16'd4;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Eligibility per peripheral source.
  logic [NUM_SRC-1:0] elig;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    if (UNUSED_SET[i]) begin : g_hole
      assign elig[i] = 1'b0;
    end else begin : g_live
      assign elig[i] = irq_req[i] & ~irq_mask[i] & level_ok;
    end
  end

  logic             pk_found;
  logic [SRC_W-1:0] pk_idx;

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .elig  (elig),
    .found (pk_found),
    .idx   (pk_idx)
  );

  irq_wake_qual #(
    .N           (NUM_SRC),
    .HALT_SET    (HALT_SET),
    .AHALT_EXTRA (AHALT_EXTRA),
    .SLAVE_SRC   (SLAVE_SRC)
  ) u_wake (
    .req     (irq_req),
    .mode    (lp_mode),
    .slave   (spi_slave),
    .rst_req (rst_req),
    .wake    (wake)
  );

  // Next-state of the grant registers.
  logic             vld_d, vld_q;
  logic             load_en;
  logic [SRC_W-1:0] src_d, src_q;
  logic [15:0]      vec_d, vec_q;

  always_comb begin
    load_en = 1'b0;
    src_d   = src_q;
    vec_d   = vec_q;
    if (ack) begin
      if (rst_req) begin
        load_en = 1'b1;
        src_d   = ID_RESET;
        vec_d   = VEC_TOP;
      end else if (trap_req) begin
        load_en = 1'b1;
        src_d   = ID_TRAP;
        vec_d   = TRAP_VEC;
      end else if (pk_found) begin
        load_en = 1'b1;
        src_d   = pk_idx;
        vec_d   = vec_of(PERI_VEC, pk_idx);
      end
    end
    vld_d = load_en;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      src_q <= ID_RESET;
      vec_q <= VEC_TOP;
    end else begin
      vld_q <= vld_d;
      if (load_en) begin
        src_q <= src_d;
        vec_q <= vec_d;
      end
    end
  end

  assign gnt_valid = vld_q;
  assign gnt_src   = src_q;
  assign gnt_vec   = vec_q;

endmodule

// File: rtl/irq_vector_arb_chk.sv
module irq_vector_arb_chk
  import irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_req,
  input logic               trap_req,
  input logic [NUM_SRC-1:0] irq_req,
  input logic               level_ok,
  input logic               spi_slave,
  input logic [1:0]         lp_mode,
  input logic               ack,
  input logic               gnt_valid,
  input logic [4:0]         gnt_src,
  input logic [15:0]        gnt_vec,
  input logic               wake
);

  // R2
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && rst_req) |=> (gnt_valid && gnt_src == ID_RESET && gnt_vec == 16'hFFFE));

  // R3
  trap_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && trap_req && !rst_req) |=> (gnt_valid && gnt_src == ID_TRAP && gnt_vec == 16'hFFFC));

  // R4
  vec_matches_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_src < 5'(NUM_SRC)) |-> (gnt_vec == 16'hFFFA - {10'd0, gnt_src, 1'b0}));

  // R5
  level_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !level_ok && !rst_req && !trap_req) |=> !gnt_valid);

  // R6
  no_hole_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_src != 5'd0 && gnt_src != 5'd6));

  // R7
  valid_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> (!gnt_valid && $stable(gnt_src) && $stable(gnt_vec)));

  // R9
  ahalt_src1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode == LP_AHALT && irq_req[1]) |-> wake);

  // R10
  run_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode == LP_RUN || lp_mode == LP_RSVD) |-> !wake);

  // R8
  halt_slave_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode == LP_HALT && irq_req[7] && spi_slave) |-> wake);

endmodule

bind irq_vector_arb irq_vector_arb_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .rst_n (rst_sync_n),
  .*
);

// File: tb/test_irq_vector_arb.sv
module test_irq_vector_arb;

  localparam int CLK_P = 10;
  localparam int N     = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rst_req, trap_req, level_ok, spi_slave, ack;
  logic [N-1:0]  irq_req, irq_mask;
  logic [1:0]    lp_mode;
  logic          gnt_valid, wake;
  logic [4:0]    gnt_src;
  logic [15:0]   gnt_vec;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_src;
  int exp_vec;

  always #(CLK_P/2) clk = ~clk;

  irq_vector_arb i_irq_vector_arb (
    .clk, .rst_n, .rst_req, .trap_req, .irq_req, .irq_mask, .level_ok,
    .spi_slave, .lp_mode, .ack, .gnt_valid, .gnt_src, .gnt_vec, .wake
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Lowest eligible peripheral, -1 if none; holes 0 and 6 excluded.
  function automatic int best(input logic [N-1:0] rq, input logic [N-1:0] mk,
                              input logic lv);
    for (int i = 0; i < N; i++)
      if (rq[i] && !mk[i] && lv && i != 0 && i != 6) return i;
    return -1;
  endfunction

  task automatic grant(input logic rr, input logic tr, input logic [N-1:0] rq,
                       input logic [N-1:0] mk, input logic lv, input string req);
    int w;
    bit ev;
    @(negedge clk);
    rst_req = rr; trap_req = tr; irq_req = rq; irq_mask = mk; level_ok = lv;
    ack = 1'b1;
    w  = best(rq, mk, lv);
    ev = 1'b1;
    if (rr)          begin exp_src = 31; exp_vec = 16'hFFFE; end
    else if (tr)     begin exp_src = 30; exp_vec = 16'hFFFC; end
    else if (w >= 0) begin exp_src = w;  exp_vec = 16'hFFFA - 2 * w; end
    else             ev = 1'b0;
    @(negedge clk);
    ack = 1'b0;
    chk(gnt_valid == ev, req, "valid", gnt_valid, ev);
    chk(gnt_src == exp_src, req, "src", gnt_src, exp_src);
    chk(gnt_vec == exp_vec, req, "vec", gnt_vec, exp_vec);
    @(negedge clk);
    // R7: one-cycle valid, values held
    chk(gnt_valid == 1'b0, "R7", "valid drop", gnt_valid, 0);
    chk(gnt_src == exp_src && gnt_vec == exp_vec, "R7", "hold", gnt_vec, exp_vec);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rst_req = 0; trap_req = 0; level_ok = 0; spi_slave = 0;
    ack = 0; irq_req = '0; irq_mask = '0; lp_mode = 2'b00;
    exp_src = 31; exp_vec = 16'hFFFE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1
    chk(gnt_valid == 0, "R1", "valid", gnt_valid, 0);
    chk(gnt_src == 31, "R1", "src", gnt_src, 31);
    chk(gnt_vec == 16'hFFFE, "R1", "vec", gnt_vec, 16'hFFFE);
    chk(wake == 0, "R1", "wake", wake, 0);

    // R4 R5 R6: every single source, mask and level combination
    for (int n = 0; n < N; n++)
      for (int m = 0; m < 2; m++)
        for (int l = 0; l < 2; l++)
          grant(0, 0, N'(1) << n, m ? (N'(1) << n) : '0, l[0], "R5");

    // R4: every pair, lowest wins
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        grant(0, 0, (N'(1) << a) | (N'(1) << b), '0, 1'b1, "R4");

    // R2 and R3: unmaskable, priority order
    grant(1, 1, '1, '1, 1'b0, "R2");
    grant(1, 0, '1, '0, 1'b1, "R2");
    grant(0, 1, '1, '1, 1'b0, "R3");
    grant(0, 1, '1, '0, 1'b1, "R3");

    // R6: only holes requested, then nothing at all
    grant(0, 0, 12'h041, '0, 1'b1, "R6");
    grant(0, 0, '0, '0, 1'b1, "R6");

    // R8 R9 R10: wake for every source, mode and slave flag, all masked
    for (int md = 0; md < 4; md++)
      for (int sl = 0; sl < 2; sl++)
        for (int n = -1; n < N; n++) begin
          bit ew;
          @(negedge clk);
          lp_mode = 2'(md); spi_slave = sl[0]; irq_mask = '1; trap_req = 1'b0;
          rst_req = (n < 0);
          irq_req = (n < 0) ? '0 : (N'(1) << n);
          if (md == 1 || md == 2)
            ew = (n < 0) || (n >= 2 && n <= 5) || (n == 7 && sl == 1) ||
                 (md == 2 && n == 1);
          else
            ew = 1'b0;
          #1;
          chk(wake == ew, (md == 2) ? "R9" : (md == 1) ? "R8" : "R10",
              "wake", wake, ew);
        end

    // R10: trap alone never wakes
    @(negedge clk);
    lp_mode = 2'b10; rst_req = 0; irq_req = '0; trap_req = 1'b1;
    #1;
    chk(wake == 0, "R10", "trap wake", wake, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule